// File: doc/BRIEF.md
# Quadrature Position Counter with Dual Edge Capture

This block turns the two phase signals of an incremental encoder into a signed position count. Every legal change of either phase moves the count by one, so one encoder line produces four counts. The phase pair runs through a small phase-tracking state machine. Each cycle it compares the newly sampled pair with the pair it holds, and classifies the move as a step up, a step down, no change, or an illegal jump where both phases changed at once. A configuration input swaps the meaning of up and down, so a reversed mounting can be corrected without rewiring. An illegal jump leaves the count alone and raises a sticky error flag.

Two capture channels copy the running count when an external pin shows an edge. One channel watches the latch pin and the other watches the gate pin. Each channel has a rising-edge request bit, a falling-edge request bit and a continuous-mode bit. The gate channel also has a gate-function bit, and while that bit is high the gate pin captures nothing. The encoder phases and both pins pass through two-flop synchronisers. All logic runs on one clock with a synchronous, active-high reset.

Phase states: `PH_00`, `PH_10`, `PH_11` and `PH_01`, named after {A,B}. After reset the state is `PH_00`, and each cycle it moves to the sampled pair. The forward moves are `PH_00`→`PH_10`→`PH_11`→`PH_01`→`PH_00`. The backward moves go the other way round. The diagonal moves (`PH_00`↔`PH_11`, `PH_10`↔`PH_01`) are illegal.

Capture states and their transitions:
- `CAP_IDLE`→`CAP_ARMED` when a request bit is high.
- `CAP_ARMED`→`CAP_DONE` on a selected edge, which stores the count.
- `CAP_ARMED`→`CAP_IDLE` when both request bits are low.
- `CAP_DONE`→`CAP_IDLE` when both request bits are low.
- Any state →`CAP_CONT` when continuous mode is set.
- `CAP_CONT`→`CAP_DONE`, `CAP_ARMED` or `CAP_IDLE` when continuous mode is cleared. `CAP_DONE` is taken if a capture is flagged and a request bit is high. `CAP_ARMED` is taken if only a request bit is high. `CAP_IDLE` is taken otherwise.

Top module: `qenc_latch_counter`

## Requirements
- R1: The count steps +1 on each forward move of {A,B} in the order 00→10→11→01→00, and −1 on each move in the opposite order. One full encoder line therefore gives four counts.
- R2: With `dir_invert` high, forward moves decrement the count and backward moves increment it.
- R3: The count is a 32-bit two's complement value that wraps. One down step from 0 gives 0xFFFFFFFF, and one up step from 0xFFFFFFFF gives 0.
- R4: A move where A and B change in the same sample leaves the count unchanged. It sets `seq_err`, which stays high until reset.
- R5: `dir_down` is 1 when the last counted step decremented the count, and 0 when it incremented the count.
- R6: In one-shot mode, an edge of the latch pin selected by `lat_pos_req` (rising) or `lat_neg_req` (falling) stores the count into `lat_val` and sets `lat_valid`. An edge of the unselected polarity is ignored.
- R7: After a one-shot capture, further pin edges change nothing until both request bits have gone low and a request bit is set again.
- R8: A valid flag is low in the cycle after both of its request bits are low.
- R9: With `lat_cont` high, every selected edge overwrites `lat_val` without re-arming.
- R10: The gate pin captures into `gate_val` and `gate_valid`, separately from the latch channel, with its own request and continuous bits. While `gate_func_en` is high, gate pin edges capture nothing.
- R11: After reset the count, both capture registers, both valid flags, `seq_err` and `dir_down` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| latch_pin | input | 1 | Capture pin for the latch channel |
| gate_pin | input | 1 | Capture pin for the gate channel |
| dir_invert | input | 1 | Swap the counting direction |
| lat_pos_req | input | 1 | Latch channel: capture on rising edge |
| lat_neg_req | input | 1 | Latch channel: capture on falling edge |
| lat_cont | input | 1 | Latch channel: continuous mode |
| gate_func_en | input | 1 | Gate function active; blocks gate captures |
| gate_pos_req | input | 1 | Gate channel: capture on rising edge |
| gate_neg_req | input | 1 | Gate channel: capture on falling edge |
| gate_cont | input | 1 | Gate channel: continuous mode |
| count | output | 32 | Signed position count |
| dir_down | output | 1 | Last counted step was a decrement |
| seq_err | output | 1 | Sticky illegal-move flag |
| lat_val | output | 32 | Latch channel captured count |
| lat_valid | output | 1 | Latch channel capture valid |
| gate_val | output | 32 | Gate channel captured count |
| gate_valid | output | 1 | Gate channel capture valid |

## Verification
On every cycle the assertions check the following:
- The count never moves by more than one.
- A classified illegal move freezes the count.
- The error flag never falls.
- A valid flag drops one cycle after its requests clear.
- The gate function keeps the gate capture empty.
- A newly raised valid flag carries the count of the cycle before.

Only the bench scenarios show the rest. These are the decode order and direction, the inversion bit, the wrap at both ends and the edge polarity selection. They also cover the one-shot refusal of later edges, the re-arm cycle and continuous overwriting.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Phase pair {A,B} held by the decoder
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

    // Classified move between two samples
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    // Capture channel states
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_DONE  = 2'd2,
        CAP_CONT  = 2'd3
    } cap_state_e;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  a,
    input  logic  b,
    output step_e step
);

    phase_e phase_q;
    phase_e sample;

    assign sample = phase_e'({a, b});

    // state register: always follows the sampled pair
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_00;
        else     phase_q <= sample;
    end

    // output: classify the move from the held phase to the sample
    always_comb begin
        step = STEP_NONE;
        unique case (phase_q)
            PH_00: begin
                if      (sample == PH_10) step = STEP_UP;
                else if (sample == PH_01) step = STEP_DN;
                else if (sample == PH_11) step = STEP_BAD;
            end
            PH_10: begin
                if      (sample == PH_11) step = STEP_UP;
                else if (sample == PH_00) step = STEP_DN;
                else if (sample == PH_01) step = STEP_BAD;
            end
            PH_11: begin
                if      (sample == PH_01) step = STEP_UP;
                else if (sample == PH_10) step = STEP_DN;
                else if (sample == PH_00) step = STEP_BAD;
            end
            PH_01: begin
                if      (sample == PH_00) step = STEP_UP;
                else if (sample == PH_11) step = STEP_DN;
                else if (sample == PH_10) step = STEP_BAD;
            end
        endcase
    end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    input  logic             invert,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             err
);

    logic [CNT_W-1:0] count_q;
    logic             dir_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            dir_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (step)
                STEP_NONE: ;
                STEP_UP: begin
                    count_q <= invert ? count_q - 1'b1 : count_q + 1'b1;
                    dir_q   <= invert;
                end
                STEP_DN: begin
                    count_q <= invert ? count_q + 1'b1 : count_q - 1'b1;
                    dir_q   <= ~invert;
                end
                STEP_BAD: err_q <= 1'b1;
            endcase
        end
    end

    assign count    = count_q;
    assign dir_down = dir_q;
    assign err      = err_q;

endmodule

// File: rtl/qenc_capture.sv
module qenc_capture
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             req_rise,
    input  logic             req_fall,
    input  logic             cont_en,
    input  logic             pin,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_valid
);

    cap_state_e       state_q, state_d;
    logic             pin_q;
    logic [CNT_W-1:0] val_q;
    logic             valid_q;
    logic             req_any;
    logic             hit;
    logic             take;

    assign req_any = req_rise | req_fall;
    assign hit     = enable & ((req_rise & pin & ~pin_q) | (req_fall & ~pin & pin_q));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CAP_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: begin
                if      (cont_en) state_d = CAP_CONT;
                else if (req_any) state_d = CAP_ARMED;
            end
            CAP_ARMED: begin
                if      (cont_en)  state_d = CAP_CONT;
                else if (!req_any) state_d = CAP_IDLE;
                else if (hit)      state_d = CAP_DONE;
            end
            CAP_DONE: begin
                if      (cont_en)  state_d = CAP_CONT;
                else if (!req_any) state_d = CAP_IDLE;
            end
            CAP_CONT: begin
                if (!cont_en) begin
                    if      (req_any && valid_q) state_d = CAP_DONE;
                    else if (req_any)            state_d = CAP_ARMED;
                    else                         state_d = CAP_IDLE;
                end
            end
        endcase
    end

    // output: capture strobe for this cycle
    always_comb begin
        take = 1'b0;
        unique case (state_q)
            CAP_IDLE:  take = 1'b0;
            CAP_ARMED: take = hit & ~cont_en;
            CAP_DONE:  take = 1'b0;
            CAP_CONT:  take = hit & cont_en;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q   <= 1'b0;
            val_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            pin_q <= pin;
            if (take) val_q <= count;
            if (!req_any)  valid_q <= 1'b0;
            else if (take) valid_q <= 1'b1;
        end
    end

    assign cap_val   = val_q;
    assign cap_valid = valid_q;

endmodule

// File: rtl/qenc_latch_counter.sv
module qenc_latch_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             latch_pin,
    input  logic             gate_pin,
    input  logic             dir_invert,
    input  logic             lat_pos_req,
    input  logic             lat_neg_req,
    input  logic             lat_cont,
    input  logic             gate_func_en,
    input  logic             gate_pos_req,
    input  logic             gate_neg_req,
    input  logic             gate_cont,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             seq_err,
    output logic [CNT_W-1:0] lat_val,
    output logic             lat_valid,
    output logic [CNT_W-1:0] gate_val,
    output logic             gate_valid
);

    localparam int N_CAP = 2;
    localparam int N_IN  = 2 + N_CAP;

    logic [N_IN-1:0]  raw_in, sync_in;
    step_e            dec_step;

    logic [N_CAP-1:0] ch_en, ch_rise, ch_fall, ch_cont, ch_pin, ch_valid;
    logic [CNT_W-1:0] ch_val [N_CAP];

    assign raw_in = {gate_pin, latch_pin, enc_b, enc_a};

    qenc_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    qenc_decoder u_dec (
        .clk  (clk),
        .rst  (rst),
        .a    (sync_in[0]),
        .b    (sync_in[1]),
        .step (dec_step)
    );

    qenc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (dec_step),
        .invert   (dir_invert),
        .count    (count),
        .dir_down (dir_down),
        .err      (seq_err)
    );

    // channel 0: latch pin, channel 1: gate pin
    assign ch_en   = {~gate_func_en, 1'b1};
    assign ch_rise = {gate_pos_req, lat_pos_req};
    assign ch_fall = {gate_neg_req, lat_neg_req};
    assign ch_cont = {gate_cont, lat_cont};
    assign ch_pin  = sync_in[N_IN-1:2];

    for (genvar g = 0; g < N_CAP; g++) begin : g_cap
        qenc_capture #(.CNT_W(CNT_W)) u_cap (
            .clk       (clk),
            .rst       (rst),
            .enable    (ch_en[g]),
            .req_rise  (ch_rise[g]),
            .req_fall  (ch_fall[g]),
            .cont_en   (ch_cont[g]),
            .pin       (ch_pin[g]),
            .count     (count),
            .cap_val   (ch_val[g]),
            .cap_valid (ch_valid[g])
        );
    end

    assign lat_val    = ch_val[0];
    assign lat_valid  = ch_valid[0];
    assign gate_val   = ch_val[1];
    assign gate_valid = ch_valid[1];

endmodule

// File: rtl/qenc_latch_counter_chk.sv
module qenc_latch_counter_chk
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input step_e            dec_step,
    input logic [CNT_W-1:0] count,
    input logic             seq_err,
    input logic             lat_pos_req,
    input logic             lat_neg_req,
    input logic             lat_cont,
    input logic [CNT_W-1:0] lat_val,
    input logic             lat_valid,
    input logic             gate_func_en,
    input logic             gate_valid
);

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)); // R1

    AST_BAD_MOVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dec_step == STEP_BAD) |=> $stable(count)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err); // R4

    AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!lat_pos_req && !lat_neg_req) |=> !lat_valid); // R8

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lat_valid && !lat_cont && (lat_pos_req || lat_neg_req)) |=> $stable(lat_val)); // R7

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
        $rose(lat_valid) |-> (lat_val == $past(count))); // R6

    AST_GATE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (gate_func_en && !gate_valid) |=> !gate_valid); // R10

endmodule

bind qenc_latch_counter qenc_latch_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dec_step     (dec_step),
    .count        (count),
    .seq_err      (seq_err),
    .lat_pos_req  (lat_pos_req),
    .lat_neg_req  (lat_neg_req),
    .lat_cont     (lat_cont),
    .lat_val      (lat_val),
    .lat_valid    (lat_valid),
    .gate_func_en (gate_func_en),
    .gate_valid   (gate_valid)
);

// File: tb/qenc_latch_counter_tb.sv
module qenc_latch_counter_tb;

    typedef enum int {SEL_CNT, SEL_DIR, SEL_ERR, SEL_LVAL, SEL_LV, SEL_GVAL, SEL_GV} sel_e;

    typedef struct {
        string       req;
        sel_e        sel;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        enc_a, enc_b, latch_pin, gate_pin;
    logic        dir_invert, lat_pos_req, lat_neg_req, lat_cont;
    logic        gate_func_en, gate_pos_req, gate_neg_req, gate_cont;
    logic [31:0] count, lat_val, gate_val;
    logic        dir_down, seq_err, lat_valid, gate_valid;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          idx      = 0;
    logic [31:0] exp_cnt  = '0;
    bit          done     = 1'b0;

    always #10 clk = ~clk;

    qenc_latch_counter u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .latch_pin(latch_pin), .gate_pin(gate_pin), .dir_invert(dir_invert),
        .lat_pos_req(lat_pos_req), .lat_neg_req(lat_neg_req), .lat_cont(lat_cont),
        .gate_func_en(gate_func_en), .gate_pos_req(gate_pos_req),
        .gate_neg_req(gate_neg_req), .gate_cont(gate_cont),
        .count(count), .dir_down(dir_down), .seq_err(seq_err),
        .lat_val(lat_val), .lat_valid(lat_valid),
        .gate_val(gate_val), .gate_valid(gate_valid)
    );

    function automatic logic [1:0] phase_of(int i);
        int m = ((i % 4) + 4) % 4;
        case (m)
            0:       return 2'b00;
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_phase();
        logic [1:0] p;
        p = phase_of(idx);
        @(negedge clk);
        enc_a = p[1];
        enc_b = p[0];
        settle(6);
    endtask

    task automatic fwd(int n);
        for (int i = 0; i < n; i++) begin
            idx++;
            exp_cnt = dir_invert ? exp_cnt - 1 : exp_cnt + 1;
            drive_phase();
        end
    endtask

    task automatic rev(int n);
        for (int i = 0; i < n; i++) begin
            idx--;
            exp_cnt = dir_invert ? exp_cnt + 1 : exp_cnt - 1;
            drive_phase();
        end
    endtask

    task automatic pin_latch(logic v);
        @(negedge clk);
        latch_pin = v;
        settle(6);
    endtask

    task automatic pin_gate(logic v);
        @(negedge clk);
        gate_pin = v;
        settle(6);
    endtask

    task automatic expect_val(string req, sel_e sel, logic [31:0] v);
        item_t it;
        it.req = req;
        it.sel = sel;
        it.exp = v;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // monitor: pop expected items and compare at the falling edge
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sb_q.size() != 0);
            @(negedge clk);
            it = sb_q.pop_front();
            case (it.sel)
                SEL_CNT:  act = count;
                SEL_DIR:  act = {31'd0, dir_down};
                SEL_ERR:  act = {31'd0, seq_err};
                SEL_LVAL: act = lat_val;
                SEL_LV:   act = {31'd0, lat_valid};
                SEL_GVAL: act = gate_val;
                default:  act = {31'd0, gate_valid};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s %s: actual 0x%08h expected 0x%08h", it.req, it.sel.name(), act, it.exp);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        rst = 1'b1;
        enc_a = 0; enc_b = 0; latch_pin = 0; gate_pin = 0;
        dir_invert = 0; lat_pos_req = 0; lat_neg_req = 0; lat_cont = 0;
        gate_func_en = 0; gate_pos_req = 0; gate_neg_req = 0; gate_cont = 0;
        settle(5);
        rst = 1'b0;
        settle(3);

        // R11 reset state
        expect_val("R11", SEL_CNT, 32'd0);
        expect_val("R11", SEL_LVAL, 32'd0);
        expect_val("R11", SEL_LV, 32'd0);
        expect_val("R11", SEL_GV, 32'd0);
        expect_val("R11", SEL_ERR, 32'd0);
        expect_val("R11", SEL_DIR, 32'd0);

        // R1 forward: one line gives four counts
        fwd(4);
        expect_val("R1", SEL_CNT, 32'd4);
        fwd(4);
        expect_val("R1", SEL_CNT, 32'd8);
        expect_val("R5", SEL_DIR, 32'd0);
        rev(3);
        expect_val("R1", SEL_CNT, 32'd5);
        expect_val("R5", SEL_DIR, 32'd1);

        // R3 wrap at zero in both directions
        rev(5);
        expect_val("R3", SEL_CNT, 32'd0);
        rev(1);
        expect_val("R3", SEL_CNT, 32'hFFFF_FFFF);
        fwd(1);
        expect_val("R3", SEL_CNT, 32'd0);
        fwd(4);
        expect_val("R1", SEL_CNT, exp_cnt);

        // R2 inverted direction
        @(negedge clk); dir_invert = 1'b1;
        fwd(2);
        expect_val("R2", SEL_CNT, 32'd2);
        expect_val("R5", SEL_DIR, 32'd1);
        @(negedge clk); dir_invert = 1'b0;

        // R6 one-shot on rising edge
        @(negedge clk); lat_pos_req = 1'b1;
        settle(2);
        pin_latch(1'b1);
        expect_val("R6", SEL_LV, 32'd1);
        expect_val("R6", SEL_LVAL, 32'd2);
        pin_latch(1'b0);
        fwd(3);
        pin_latch(1'b1);
        expect_val("R7", SEL_LVAL, 32'd2);
        pin_latch(1'b0);

        // R8 valid clears with requests
        @(negedge clk); lat_pos_req = 1'b0;
        settle(2);
        expect_val("R8", SEL_LV, 32'd0);

        // R6 falling edge only
        @(negedge clk); lat_neg_req = 1'b1;
        settle(2);
        pin_latch(1'b1);
        expect_val("R6", SEL_LV, 32'd0);
        pin_latch(1'b0);
        expect_val("R7", SEL_LV, 32'd1);
        expect_val("R7", SEL_LVAL, 32'd5);

        // R9 continuous overwrite
        @(negedge clk); lat_cont = 1'b1;
        settle(2);
        fwd(2);
        pin_latch(1'b1);
        pin_latch(1'b0);
        expect_val("R9", SEL_LVAL, 32'd7);
        fwd(1);
        pin_latch(1'b1);
        pin_latch(1'b0);
        expect_val("R9", SEL_LVAL, 32'd8);
        @(negedge clk); lat_cont = 1'b0; lat_neg_req = 1'b0;
        settle(2);

        // R10 gate channel
        @(negedge clk); gate_func_en = 1'b1; gate_neg_req = 1'b1;
        settle(2);
        pin_gate(1'b1);
        pin_gate(1'b0);
        expect_val("R10", SEL_GV, 32'd0);
        expect_val("R10", SEL_GVAL, 32'd0);
        @(negedge clk); gate_func_en = 1'b0;
        fwd(2);
        pin_gate(1'b1);
        pin_gate(1'b0);
        expect_val("R10", SEL_GV, 32'd1);
        expect_val("R10", SEL_GVAL, 32'd10);
        expect_val("R10", SEL_LVAL, 32'd8);

        // R4 illegal move
        idx += 2;
        drive_phase();
        expect_val("R4", SEL_CNT, 32'd10);
        expect_val("R4", SEL_ERR, 32'd1);
        fwd(1);
        expect_val("R4", SEL_CNT, 32'd11);
        expect_val("R4", SEL_ERR, 32'd1);

        done = 1'b1;
        settle(2);
        summary();
    end

endmodule